// File: doc/BRIEF.md
# Extended RV64 Integer ALU

This block is the integer execution datapath of a 64-bit core that carries the bit-manipulation and conditional-zero operations plus a set of fused micro-operation forms. It is purely combinational: two 64-bit source operands and a 7-bit operation code enter, and a 64-bit result leaves in the same cycle. Operand selection, immediate expansion and instruction decode happen upstream, and the issue stage presents the already-decoded operation code.

The upper three opcode bits pick an operation family. Inside each family the low four bits pick the operation. The fused forms fold common instruction pairs into one operation. These are an add of bit 0 of the first source, an add of the first source shifted right by 29 to 32, and a merge of an upper-immediate load with an immediate add. The same group also holds word adds cut down to 1, 8 or 16 bits, and logic operations reduced to bit 0 or to a zero-extended low half-word.

Top module: `rv64_ext_alu`

## Requirements
- R1: Opcode bits [6:4] select the family: 000 shift/bit, 001 word, 010 add, 011 subtract/compare, 100 logic, 101 permute, 110 narrowed logic, 111 conditional zero. Any opcode not listed in R2 to R12 gives a result of zero, and so do all-zero inputs.
- R2: The shift amount is src2[5:0]. Opcode 0x01 shifts left, 0x05 shifts right logically, 0x07 shifts right arithmetically, 0x09 rotates left and 0x0B rotates right. Opcode 0x00 zero-extends src1[31:0] and then shifts it left.
- R3: With index src2[5:0], 0x02 clears that bit of src1, 0x03 sets it and 0x04 inverts it. 0x06 returns that bit of src1 in bit 0 and zeros above it.
- R4: Each of these computes a 32-bit value and sign-extends it to 64 bits. 0x10 gives src1+src2 and 0x12 gives src1-src2. 0x11 gives src1[0]+src2. 0x13 gives the sign-extended src2[11:0] plus {src2[31:12],12'b0}.
- R5: For s = src1+src2, 0x14 returns s[0], 0x15 returns s[7:0] and 0x16 returns s[15:0] with zeros above. 0x17 returns s[15:0] sign-extended.
- R6: The word shifts use src2[4:0] on src1[31:0] and sign-extend bit 31 of the result. 0x18 shifts left, 0x19 shifts right logically, 0x1A shifts right arithmetically from bit 31, 0x1C rotates left and 0x1D rotates right.
- R7: 0x21 gives src1+src2, and 0x22 gives src1[0]+src2. 0x20 adds zero-extended src1[31:0] to src2. 0x23 gives the sign-extended src2[11:0] plus {src2[63:12],12'b0}. 0x24..0x27 add src1 shifted right logically by 29..32 to src2. 0x29, 0x2B, 0x2D and 0x2F add src1 shifted left by 1, 2, 3 and 4 to src2. 0x28, 0x2A and 0x2C do the same for shifts of 1, 2 and 3, starting from zero-extended src1[31:0].
- R8: 0x30 gives src1-src2. 0x31 and 0x32 return 1 or 0 for an unsigned or signed src1<src2. 0x34 and 0x35 return the unsigned maximum and minimum, and 0x36 and 0x37 return the signed ones.
- R9: 0x40 is AND, 0x42 is OR and 0x44 is XOR. 0x41, 0x43 and 0x45 perform the same operations with src2 inverted first. 0x46 sets each byte to 0xFF when the matching src1 byte is nonzero and to 0x00 when it is zero.
- R10: 0x48 and 0x4A sign-extend src1 from 8 and from 16 bits. 0x49 returns {src2[7:0],src1[7:0]} with zeros above. 0x4B returns {src2[15:0],src1[15:0]} sign-extended from bit 31. 0x52 returns {src2[31:0],src1[31:0]}. 0x51 reverses the byte order of src1, and 0x50 reverses the bits inside each byte of src1.
- R11: Opcodes 0x60..0x67 have the form {3'b110, f, n}. For f = 000, 001, 010 and 011 the base operation is AND, OR, XOR and the byte OR-combine of R9. With n=0 the result is bit 0 of the base value. With n=1 it is the low 16 bits of the base value, zero-extended.
- R12: 0x74 returns 0 when src2 is zero and src1 otherwise. 0x76 returns 0 when src2 is nonzero and src1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand or shift amount/immediate |
| op_i | input | 7 | Decoded operation code |
| result_o | output | 64 | Operation result, valid in the same cycle |

## Verification
The block holds no state, so a fault shows as a wrong result in the same evaluation as the bad opcode. There is no later symptom to wait for. The sweep therefore drives every one of the 128 opcodes against corner operands and pseudo-random operands, and compares each result with an arithmetic model. A wrong family select or an undefined code that leaks a value appears as a nonzero result where zero is expected. Width mistakes show up as broken sign or zero extension in the upper word or upper bits.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = XLEN / 2;
  localparam int OPW  = 7;
  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = $clog2(WLEN);
  localparam int NBYTE = XLEN / 8;

  typedef logic [XLEN-1:0] xword_t;

  typedef enum logic [2:0] {
    GRP_SHIFT  = 3'b000,
    GRP_WORD   = 3'b001,
    GRP_ADD    = 3'b010,
    GRP_SUB    = 3'b011,
    GRP_LOGIC  = 3'b100,
    GRP_PERM   = 3'b101,
    GRP_NARROW = 3'b110,
    GRP_CZERO  = 3'b111
  } op_grp_e;

  function automatic xword_t sext_w(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){v[WLEN-1]}}, v};
  endfunction

  function automatic xword_t zext_w(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){1'b0}}, v};
  endfunction
endpackage

// File: rtl/alu_ext_shift.sv
module alu_ext_shift
  import alu_ext_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  xword_t         a_i,
  input  logic [SHW-1:0] amt_i,
  output xword_t         res_o
);
  logic [WSHW-1:0] wamt;
  logic [SHW:0]    rinv;
  logic [WSHW:0]   wrinv;
  logic [WLEN-1:0] aw;
  xword_t          bitsel;

  always_comb begin
    wamt   = amt_i[WSHW-1:0];
    aw     = a_i[WLEN-1:0];
    rinv   = (SHW+1)'(XLEN) - {1'b0, amt_i};
    wrinv  = (WSHW+1)'(WLEN) - {1'b0, wamt};
    bitsel = xword_t'(1) << amt_i;
    unique case (op_i)
      7'h00: res_o = zext_w(aw) << amt_i;
      7'h01: res_o = a_i << amt_i;
      7'h02: res_o = a_i & ~bitsel;
      7'h03: res_o = a_i | bitsel;
      7'h04: res_o = a_i ^ bitsel;
      7'h05: res_o = a_i >> amt_i;
      7'h06: res_o = {{(XLEN-1){1'b0}}, a_i[amt_i]};
      7'h07: res_o = xword_t'($signed(a_i) >>> amt_i);
      7'h09: res_o = (a_i << amt_i) | (a_i >> rinv);
      7'h0B: res_o = (a_i >> amt_i) | (a_i << rinv);
      7'h18: res_o = sext_w(aw << wamt);
      7'h19: res_o = sext_w(aw >> wamt);
      7'h1A: res_o = sext_w(WLEN'($signed(aw) >>> wamt));
      7'h1C: res_o = sext_w((aw << wamt) | (aw >> wrinv));
      7'h1D: res_o = sext_w((aw >> wamt) | (aw << wrinv));
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == 7'h06)
      assert_bext_single_bit_R3: assert (res_o[XLEN-1:1] == '0)
        else $error("bit extract leaked upper bits");
    if (op_i[6:3] == 4'b0011)
      assert_word_shift_sext_R6: assert (res_o[XLEN-1:WLEN] == {(XLEN-WLEN){res_o[WLEN-1]}})
        else $error("word shift not sign-extended");
  end
endmodule

// File: rtl/alu_ext_arith.sv
module alu_ext_arith
  import alu_ext_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  xword_t         a_i,
  input  xword_t         b_i,
  output xword_t         res_o
);
  xword_t          sum, diff, a_uw, odd_a, lui_sum, max_u, min_u, max_s, min_s;
  logic [WLEN-1:0] sum_w, diff_w, odd_w, lui_w;
  logic            lt_u, lt_s;

  always_comb begin
    sum     = a_i + b_i;
    diff    = a_i - b_i;
    a_uw    = zext_w(a_i[WLEN-1:0]);
    odd_a   = {{(XLEN-1){1'b0}}, a_i[0]};
    lui_sum = {{(XLEN-12){b_i[11]}}, b_i[11:0]} + {b_i[XLEN-1:12], 12'b0};
    sum_w   = a_i[WLEN-1:0] + b_i[WLEN-1:0];
    diff_w  = a_i[WLEN-1:0] - b_i[WLEN-1:0];
    odd_w   = {{(WLEN-1){1'b0}}, a_i[0]} + b_i[WLEN-1:0];
    lui_w   = {{(WLEN-12){b_i[11]}}, b_i[11:0]} + {b_i[WLEN-1:12], 12'b0};
    lt_u    = a_i < b_i;
    lt_s    = $signed(a_i) < $signed(b_i);
    max_u   = lt_u ? b_i : a_i;
    min_u   = lt_u ? a_i : b_i;
    max_s   = lt_s ? b_i : a_i;
    min_s   = lt_s ? a_i : b_i;
    unique case (op_i)
      7'h10: res_o = sext_w(sum_w);
      7'h11: res_o = sext_w(odd_w);
      7'h12: res_o = sext_w(diff_w);
      7'h13: res_o = sext_w(lui_w);
      7'h14: res_o = {{(XLEN-1){1'b0}}, sum_w[0]};
      7'h15: res_o = {{(XLEN-8){1'b0}}, sum_w[7:0]};
      7'h16: res_o = {{(XLEN-16){1'b0}}, sum_w[15:0]};
      7'h17: res_o = {{(XLEN-16){sum_w[15]}}, sum_w[15:0]};
      7'h20: res_o = a_uw + b_i;
      7'h21: res_o = sum;
      7'h22: res_o = odd_a + b_i;
      7'h23: res_o = lui_sum;
      7'h24: res_o = (a_i >> 29) + b_i;
      7'h25: res_o = (a_i >> 30) + b_i;
      7'h26: res_o = (a_i >> 31) + b_i;
      7'h27: res_o = (a_i >> 32) + b_i;
      7'h28: res_o = (a_uw << 1) + b_i;
      7'h29: res_o = (a_i << 1) + b_i;
      7'h2A: res_o = (a_uw << 2) + b_i;
      7'h2B: res_o = (a_i << 2) + b_i;
      7'h2C: res_o = (a_uw << 3) + b_i;
      7'h2D: res_o = (a_i << 3) + b_i;
      7'h2F: res_o = (a_i << 4) + b_i;
      7'h30: res_o = diff;
      7'h31: res_o = {{(XLEN-1){1'b0}}, lt_u};
      7'h32: res_o = {{(XLEN-1){1'b0}}, lt_s};
      7'h34: res_o = max_u;
      7'h35: res_o = min_u;
      7'h36: res_o = max_s;
      7'h37: res_o = min_s;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i[6:2] == 5'b00100)
      assert_word_arith_sext_R4: assert (res_o[XLEN-1:WLEN] == {(XLEN-WLEN){res_o[WLEN-1]}})
        else $error("word arithmetic not sign-extended");
    if (op_i == 7'h14)
      assert_sum_bit_narrow_R5: assert (res_o[XLEN-1:1] == '0)
        else $error("sum bit leaked upper bits");
    if (op_i == 7'h15)
      assert_sum_byte_narrow_R5: assert (res_o[XLEN-1:8] == '0)
        else $error("sum byte leaked upper bits");
    if (op_i == 7'h31 || op_i == 7'h32)
      assert_compare_boolean_R8: assert (res_o[XLEN-1:1] == '0)
        else $error("compare result not boolean");
    if (op_i[6:2] == 5'b01101)
      assert_minmax_operand_R8: assert (res_o == a_i || res_o == b_i)
        else $error("min/max returned neither operand");
  end
endmodule

// File: rtl/alu_ext_logic.sv
module alu_ext_logic
  import alu_ext_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  xword_t         a_i,
  input  xword_t         b_i,
  output xword_t         res_o
);
  xword_t orc, rbyte, rbit, base;
  logic   b_zero;

  always_comb begin
    for (int k = 0; k < NBYTE; k++) begin
      orc[k*8 +: 8]               = {8{|a_i[k*8 +: 8]}};
      rbyte[(NBYTE-1-k)*8 +: 8]   = a_i[k*8 +: 8];
      for (int j = 0; j < 8; j++)
        rbit[k*8 + j]             = a_i[k*8 + 7 - j];
    end
  end

  always_comb begin
    b_zero = (b_i == '0);
    unique case (op_i[3:1])
      3'b000:  base = a_i & b_i;
      3'b001:  base = a_i | b_i;
      3'b010:  base = a_i ^ b_i;
      3'b011:  base = orc;
      default: base = '0;
    endcase
    res_o = '0;
    unique case (op_grp_e'(op_i[6:4]))
      GRP_LOGIC: begin
        unique case (op_i[3:0])
          4'h0: res_o = a_i & b_i;
          4'h1: res_o = a_i & ~b_i;
          4'h2: res_o = a_i | b_i;
          4'h3: res_o = a_i | ~b_i;
          4'h4: res_o = a_i ^ b_i;
          4'h5: res_o = ~(a_i ^ b_i);
          4'h6: res_o = orc;
          4'h8: res_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
          4'h9: res_o = {{(XLEN-16){1'b0}}, b_i[7:0], a_i[7:0]};
          4'hA: res_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
          4'hB: res_o = sext_w({b_i[15:0], a_i[15:0]});
          default: res_o = '0;
        endcase
      end
      GRP_PERM: begin
        unique case (op_i[3:0])
          4'h0: res_o = rbit;
          4'h1: res_o = rbyte;
          4'h2: res_o = {b_i[WLEN-1:0], a_i[WLEN-1:0]};
          default: res_o = '0;
        endcase
      end
      GRP_NARROW: begin
        if (!op_i[3])
          res_o = op_i[0] ? {{(XLEN-16){1'b0}}, base[15:0]}
                          : {{(XLEN-1){1'b0}}, base[0]};
      end
      GRP_CZERO: begin
        if (op_i[3:0] == 4'h4)      res_o = b_zero ? '0 : a_i;
        else if (op_i[3:0] == 4'h6) res_o = b_zero ? a_i : '0;
      end
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i[6:3] == 4'b1100 && !op_i[0])
      assert_narrow_lsb_R11: assert (res_o[XLEN-1:1] == '0)
        else $error("narrowed logic bit leaked upper bits");
    if (op_i[6:3] == 4'b1100 && op_i[0])
      assert_narrow_half_R11: assert (res_o[XLEN-1:16] == '0)
        else $error("narrowed logic half leaked upper bits");
    if (op_i == 7'h74 || op_i == 7'h76)
      assert_czero_choice_R12: assert (res_o == '0 || res_o == a_i)
        else $error("conditional zero returned a foreign value");
  end
endmodule

// File: rtl/rv64_ext_alu.sv
module rv64_ext_alu
  import alu_ext_pkg::*;
(
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  input  logic [OPW-1:0]  op_i,
  output logic [XLEN-1:0] result_o
);
  xword_t shift_res, arith_res, logic_res;

  alu_ext_shift u_shift (
    .op_i  (op_i),
    .a_i   (src1_i),
    .amt_i (src2_i[SHW-1:0]),
    .res_o (shift_res)
  );

  alu_ext_arith u_arith (
    .op_i  (op_i),
    .a_i   (src1_i),
    .b_i   (src2_i),
    .res_o (arith_res)
  );

  alu_ext_logic u_logic (
    .op_i  (op_i),
    .a_i   (src1_i),
    .b_i   (src2_i),
    .res_o (logic_res)
  );

  always_comb begin
    unique case (op_grp_e'(op_i[6:4]))
      GRP_SHIFT:        result_o = shift_res;
      GRP_WORD:         result_o = op_i[3] ? shift_res : arith_res;
      GRP_ADD, GRP_SUB: result_o = arith_res;
      default:          result_o = logic_res;
    endcase
  end

  always_comb begin
    if (op_i == 7'h0E || op_i == 7'h2E || op_i == 7'h33 || op_i == 7'h47 || op_i == 7'h7F)
      assert_undefined_zero_R1: assert (result_o == '0)
        else $error("undefined opcode produced a value");
  end
endmodule

// File: tb/rv64_ext_alu_bench.sv
module rv64_ext_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic [63:0] src1, src2, result;
  logic [6:0]  op;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv64_ext_alu u_rv64_ext_alu (
    .src1_i   (src1),
    .src2_i   (src2),
    .op_i     (op),
    .result_o (result)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] rot64(input logic [63:0] v, input int s, input bit left);
    logic [63:0] r;
    for (int i = 0; i < 64; i++)
      r[i] = left ? v[(i - s + 64) % 64] : v[(i + s) % 64];
    return r;
  endfunction

  function automatic logic [31:0] rot32(input logic [31:0] v, input int s, input bit left);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = left ? v[(i - s + 32) % 32] : v[(i + s) % 32];
    return r;
  endfunction

  function automatic logic [63:0] byte_or(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++)
      r[k*8 +: 8] = (v[k*8 +: 8] != 8'h00) ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [63:0] model(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    int          s = int'(b[5:0]);
    int          w = int'(b[4:0]);
    logic [63:0] r = 64'h0;
    logic [63:0] sum = a + b;
    logic [31:0] t;
    logic [63:0] lg;
    case (o)
      7'h00: r = {32'h0, a[31:0]} << s;
      7'h01: r = a << s;
      7'h02: begin r = a; r[s] = 1'b0; end
      7'h03: begin r = a; r[s] = 1'b1; end
      7'h04: begin r = a; r[s] = ~a[s]; end
      7'h05: r = a >> s;
      7'h06: r = {63'h0, a[s]};
      7'h07: for (int i = 0; i < 64; i++) r[i] = (i + s < 64) ? a[i + s] : a[63];
      7'h09: r = rot64(a, s, 1'b1);
      7'h0B: r = rot64(a, s, 1'b0);
      7'h10: r = sx32(sum[31:0]);
      7'h11: begin t = b[31:0] + {31'h0, a[0]}; r = sx32(t); end
      7'h12: begin t = a[31:0] - b[31:0]; r = sx32(t); end
      7'h13: begin t = {b[31:12], 12'h0} + {{20{b[11]}}, b[11:0]}; r = sx32(t); end
      7'h14: r = {63'h0, sum[0]};
      7'h15: r = {56'h0, sum[7:0]};
      7'h16: r = {48'h0, sum[15:0]};
      7'h17: r = {{48{sum[15]}}, sum[15:0]};
      7'h18: begin t = a[31:0] << w; r = sx32(t); end
      7'h19: begin t = a[31:0] >> w; r = sx32(t); end
      7'h1A: begin for (int i = 0; i < 32; i++) t[i] = (i + w < 32) ? a[i + w] : a[31]; r = sx32(t); end
      7'h1C: r = sx32(rot32(a[31:0], w, 1'b1));
      7'h1D: r = sx32(rot32(a[31:0], w, 1'b0));
      7'h20: r = b + {32'h0, a[31:0]};
      7'h21: r = sum;
      7'h22: r = b + {63'h0, a[0]};
      7'h23: r = {b[63:12], 12'h0} + {{52{b[11]}}, b[11:0]};
      7'h24, 7'h25, 7'h26, 7'h27: r = b + (a >> (29 + int'(o[1:0])));
      7'h28: r = b + ({32'h0, a[31:0]} * 2);
      7'h29: r = b + a * 2;
      7'h2A: r = b + ({32'h0, a[31:0]} * 4);
      7'h2B: r = b + a * 4;
      7'h2C: r = b + ({32'h0, a[31:0]} * 8);
      7'h2D: r = b + a * 8;
      7'h2F: r = b + a * 16;
      7'h30: r = a - b;
      7'h31: r = (a < b) ? 64'h1 : 64'h0;
      7'h32: r = ($signed(a) < $signed(b)) ? 64'h1 : 64'h0;
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a > b) ? b : a;
      7'h36: r = ($signed(a) > $signed(b)) ? a : b;
      7'h37: r = ($signed(a) > $signed(b)) ? b : a;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = a ^ ~b;
      7'h46: r = byte_or(a);
      7'h48: r = {{56{a[7]}}, a[7:0]};
      7'h49: r = {48'h0, b[7:0], a[7:0]};
      7'h4A: r = {{48{a[15]}}, a[15:0]};
      7'h4B: r = sx32({b[15:0], a[15:0]});
      7'h50: for (int i = 0; i < 64; i++) r[i] = a[(i / 8) * 8 + 7 - (i % 8)];
      7'h51: for (int k = 0; k < 8; k++) r[k*8 +: 8] = a[(7-k)*8 +: 8];
      7'h52: r = {b[31:0], a[31:0]};
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        case (o[2:1])
          2'd0: lg = a & b;
          2'd1: lg = a | b;
          2'd2: lg = a ^ b;
          default: lg = byte_or(a);
        endcase
        r = o[0] ? {48'h0, lg[15:0]} : {63'h0, lg[0]};
      end
      7'h74: r = (b == 64'h0) ? 64'h0 : a;
      7'h76: r = (b != 64'h0) ? 64'h0 : a;
      default: r = 64'h0;
    endcase
    return r;
  endfunction

  function automatic string req_tag(input logic [6:0] o);
    case (o)
      7'h00, 7'h01, 7'h05, 7'h07, 7'h09, 7'h0B: return "R2";
      7'h02, 7'h03, 7'h04, 7'h06:               return "R3";
      7'h10, 7'h11, 7'h12, 7'h13:               return "R4";
      7'h14, 7'h15, 7'h16, 7'h17:               return "R5";
      7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D:        return "R6";
      7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37: return "R8";
      7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46: return "R9";
      7'h48, 7'h49, 7'h4A, 7'h4B, 7'h50, 7'h51, 7'h52: return "R10";
      7'h74, 7'h76:                             return "R12";
      default: begin
        if (o >= 7'h20 && o <= 7'h2F && o != 7'h2E) return "R7";
        if (o >= 7'h60 && o <= 7'h67)               return "R11";
        return "R1";
      end
    endcase
  endfunction

  task automatic check_one(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [63:0] exp;
    op = o; src1 = a; src2 = b;
    #1;
    exp = model(o, a, b);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s op=%02h a=%h b=%h actual=%h expected=%h", tag, o, a, b, result, exp);
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  logic [63:0] corner [8];

  initial begin
    corner[0] = 64'h0;
    corner[1] = 64'h1;
    corner[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    corner[3] = 64'h8000_0000_0000_0000;
    corner[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    corner[5] = 64'h0000_0000_FFFF_FFFF;
    corner[6] = 64'h0000_0000_8000_0800;
    corner[7] = 64'h1234_5678_9ABC_DEF0;
    op = 7'h0; src1 = 64'h0; src2 = 64'h0;
    @(negedge clk);
    // R1: idle inputs give zero
    check_one(7'h00, 64'h0, 64'h0, "R1");
    // Directed boundaries
    check_one(7'h13, 64'h0, 64'h0000_0000_1234_5FFF, "R4");
    check_one(7'h23, 64'h0, 64'hFFFF_FFFF_FFFF_F800, "R7");
    check_one(7'h09, 64'h8000_0000_0000_0001, 64'd0, "R2");
    check_one(7'h1D, 64'hFFFF_FFFF_0000_0001, 64'd1, "R6");
    check_one(7'h67, 64'h0000_0000_0000_0100, 64'h0, "R11");
    for (int oi = 0; oi < 128; oi++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          check_one(7'(oi), corner[i], corner[j], req_tag(7'(oi)));
      for (int k = 0; k < 40; k++) begin
        logic [63:0] ra, rb;
        rng = next_rand(rng); ra = rng;
        rng = next_rand(rng); rb = rng;
        if (k % 4 == 0) rb = 64'h0;
        check_one(7'(oi), ra, rb, req_tag(7'(oi)));
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule